// File: doc/BRIEF.md
# Per-Context Priority Interrupt Arbiter

This block decides which interrupt source each target context should see next. Every source has a 3-bit priority. A shared pending vector and a shared in-flight (claimed) vector apply to all contexts. Each context has its own enable vector and its own priority threshold. For each context, the block looks for the source that is pending, enabled for that context, not in flight, and whose priority is strictly above that context's threshold. It reports the identifier of the strongest such source, or identifier 0 when no source qualifies. It also reports one interrupt request line per context.

Source slot 0 is reserved to mean "nothing to take". The pending, in-flight and enable vectors are laid out in 32-bit words, so each vector is as wide as the source count rounded up to the next multiple of 32. Bits at positions at or beyond the source count are padding. Register access, edge/level gateways and the claim/complete bookkeeping live in a neighbouring block, which feeds this one and reads its results.

Top module: `prio_irq_arbiter`

## Requirements
- R1: While reset is asserted, every context's chosen identifier and request line read 0.
- R2: A source is a candidate for a context only when its pending bit is 1, its in-flight bit is 0 and its enable bit for that context is 1. The bit for source s sits at position s of each vector.
- R3: A candidate is chosen only if its priority is strictly greater than the context's threshold. A priority equal to the threshold loses.
- R4: Among qualifying candidates, the one with the numerically largest priority is chosen.
- R5: When several qualifying candidates share the largest priority, the lowest source identifier is chosen.
- R6: When no source qualifies, the chosen identifier is 0. Source slot 0 is never chosen, even when all its bits are set.
- R7: A context's request line is 1 exactly when its chosen identifier is nonzero.
- R8: A source with priority 0 is never chosen, whatever the threshold.
- R9: Both outputs are registered. A change on any input appears on the outputs after the next rising clock edge, and not before it.
- R10: Padding bits at positions at or beyond the source count have no effect on any output.
- R11: Contexts are independent. One context's enable vector and threshold do not change another context's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | VEC_W | Pending bits, one per source slot, word-padded |
| held_i | input | VEC_W | In-flight (claimed) bits, one per source slot |
| en_i | input | N_CTX*VEC_W | Enable vectors, context c in bits [c*VEC_W +: VEC_W] |
| prio_i | input | N_SRC*3 | Source priorities, source s in bits [s*3 +: 3]; slot 0 ignored |
| thr_i | input | N_CTX*3 | Thresholds, context c in bits [c*3 +: 3] |
| claim_id_o | output | N_CTX*ID_W | Chosen identifier per context, context c in bits [c*ID_W +: ID_W] |
| irq_o | output | N_CTX | Request line per context |

## Verification
The chosen identifier and the request line both come from one register stage. Whatever inputs are present at a rising edge decide the outputs just after that edge. The bench changes inputs on a falling edge and checks results on the next falling edge, so exactly one rising edge lies between stimulus and check. For the latency requirement it also checks the outputs between the change and that edge, where they must still show the previous result. The bound checker keeps a one-cycle copy of the inputs and compares every output against that copy, never against the current inputs.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int PRIO_W = 3;
  localparam int WORD_W = 32;

  typedef logic [PRIO_W-1:0] prio_t;

  // Number of 32-bit words that hold one bit per source slot.
  function automatic int word_count(int n_src);
    return (n_src + WORD_W - 1) / WORD_W;
  endfunction

  // A priority must strictly exceed the floor to be considered.
  function automatic logic clears_floor(prio_t p, prio_t floor_p);
    return p > floor_p;
  endfunction

  // The upper (higher-numbered) half replaces the lower half only on a
  // strictly larger priority, which keeps ties on the lower identifier.
  function automatic logic upper_takes(logic lo_v, prio_t lo_p,
                                       logic hi_v, prio_t hi_p);
    return hi_v && (!lo_v || (hi_p > lo_p));
  endfunction
endpackage

// File: rtl/prio_arb_eligible.sv
module prio_arb_eligible #(
  parameter int N_SRC = 40,
  parameter int VEC_W = 64
) (
  input  logic [VEC_W-1:0] pend_i,
  input  logic [VEC_W-1:0] held_i,
  input  logic [VEC_W-1:0] en_i,
  output logic [N_SRC-1:0] cand_o
);
  genvar s;
  generate
    for (s = 0; s < N_SRC; s++) begin : g_src
      if (s == 0) begin : g_reserved
        assign cand_o[s] = 1'b0;
      end else begin : g_live
        assign cand_o[s] = pend_i[s] & ~held_i[s] & en_i[s];
      end
    end

    if (VEC_W > N_SRC) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^{pend_i[VEC_W-1:N_SRC], held_i[VEC_W-1:N_SRC],
                            en_i[VEC_W-1:N_SRC], pend_i[0], held_i[0], en_i[0]};
    end else begin : g_nopad
      logic unused_slot0;
      assign unused_slot0 = ^{pend_i[0], held_i[0], en_i[0]};
    end
  endgenerate
endmodule

// File: rtl/prio_arb_tree.sv
module prio_arb_tree
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 40,
  parameter int ID_W  = 6
) (
  input  logic [N_SRC-1:0]        cand_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  prio_t                   floor_i,
  output logic                    win_v_o,
  output logic [ID_W-1:0]         win_id_o
);
  localparam int LVL    = $clog2(N_SRC);
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES;

  // Heap-ordered nodes: node n has children 2n and 2n+1, leaves start at LEAVES.
  logic            node_v  [1:NODES-1];
  prio_t           node_p  [1:NODES-1];
  logic [ID_W-1:0] node_id [1:NODES-1];

  genvar i, n;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < N_SRC) begin : g_real
        assign node_v[LEAVES+i]  = cand_i[i] &&
                                   clears_floor(prio_i[i*PRIO_W +: PRIO_W], floor_i);
        assign node_p[LEAVES+i]  = prio_i[i*PRIO_W +: PRIO_W];
        assign node_id[LEAVES+i] = ID_W'(i);
      end else begin : g_empty
        assign node_v[LEAVES+i]  = 1'b0;
        assign node_p[LEAVES+i]  = '0;
        assign node_id[LEAVES+i] = '0;
      end
    end

    for (n = 1; n < LEAVES; n++) begin : g_node
      logic pick_hi;
      assign pick_hi    = upper_takes(node_v[2*n], node_p[2*n],
                                      node_v[2*n+1], node_p[2*n+1]);
      assign node_v[n]  = node_v[2*n] | node_v[2*n+1];
      assign node_p[n]  = pick_hi ? node_p[2*n+1]  : node_p[2*n];
      assign node_id[n] = pick_hi ? node_id[2*n+1] : node_id[2*n];
    end
  endgenerate

  logic unused_root_p;
  assign unused_root_p = ^node_p[1];

  assign win_v_o  = node_v[1];
  assign win_id_o = node_v[1] ? node_id[1] : '0;
endmodule

// File: rtl/prio_arb_context.sv
module prio_arb_context
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 40,
  parameter int VEC_W = 64,
  parameter int ID_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VEC_W-1:0]        pend_i,
  input  logic [VEC_W-1:0]        held_i,
  input  logic [VEC_W-1:0]        en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  prio_t                   floor_i,
  output logic [ID_W-1:0]         id_o,
  output logic                    req_o
);
  logic [N_SRC-1:0] cand;
  logic             win_v;
  logic [ID_W-1:0]  win_id;

  prio_arb_eligible #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_elig (
    .pend_i (pend_i),
    .held_i (held_i),
    .en_i   (en_i),
    .cand_o (cand)
  );

  prio_arb_tree #(.N_SRC(N_SRC), .ID_W(ID_W)) u_tree (
    .cand_i   (cand),
    .prio_i   (prio_i),
    .floor_i  (floor_i),
    .win_v_o  (win_v),
    .win_id_o (win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_o  <= '0;
      req_o <= 1'b0;
    end else begin
      id_o  <= win_id;
      req_o <= win_v;
    end
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 40,
  parameter int N_CTX = 2,
  localparam int VEC_W = word_count(N_SRC) * WORD_W,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VEC_W-1:0]        pend_i,
  input  logic [VEC_W-1:0]        held_i,
  input  logic [N_CTX*VEC_W-1:0]  en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [N_CTX*PRIO_W-1:0] thr_i,
  output logic [N_CTX*ID_W-1:0]   claim_id_o,
  output logic [N_CTX-1:0]        irq_o
);
  genvar c;
  generate
    for (c = 0; c < N_CTX; c++) begin : g_ctx
      prio_arb_context #(.N_SRC(N_SRC), .VEC_W(VEC_W), .ID_W(ID_W)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_i),
        .held_i  (held_i),
        .en_i    (en_i[c*VEC_W +: VEC_W]),
        .prio_i  (prio_i),
        .floor_i (thr_i[c*PRIO_W +: PRIO_W]),
        .id_o    (claim_id_o[c*ID_W +: ID_W]),
        .req_o   (irq_o[c])
      );
    end
  endgenerate
endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk
  import prio_arb_pkg::*;
#(
  parameter int N_SRC = 40,
  parameter int N_CTX = 2,
  localparam int VEC_W = word_count(N_SRC) * WORD_W,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [VEC_W-1:0]        pend_i,
  input logic [VEC_W-1:0]        held_i,
  input logic [N_CTX*VEC_W-1:0]  en_i,
  input logic [N_SRC*PRIO_W-1:0] prio_i,
  input logic [N_CTX*PRIO_W-1:0] thr_i,
  input logic [N_CTX*ID_W-1:0]   claim_id_o,
  input logic [N_CTX-1:0]        irq_o
);
  // One-cycle copy of the inputs: the outputs must match these.
  logic [VEC_W-1:0]        pend_q, held_q;
  logic [N_CTX*VEC_W-1:0]  en_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [N_CTX*PRIO_W-1:0] thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      held_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
      thr_q  <= '0;
    end else begin
      pend_q <= pend_i;
      held_q <= held_i;
      en_q   <= en_i;
      prio_q <= prio_i;
      thr_q  <= thr_i;
    end
  end

  genvar c;
  generate
    for (c = 0; c < N_CTX; c++) begin : g_chk
      logic [ID_W-1:0] id_c;
      prio_t           thr_c;
      prio_t           max_p;
      logic            any_above;
      int              first_max;

      assign id_c  = claim_id_o[c*ID_W +: ID_W];
      assign thr_c = thr_q[c*PRIO_W +: PRIO_W];

      // Linear scan: largest eligible priority and the first slot holding it.
      always_comb begin
        max_p     = '0;
        any_above = 1'b0;
        first_max = 0;
        for (int s = 1; s < N_SRC; s++) begin
          if (pend_q[s] && !held_q[s] && en_q[c*VEC_W + s]) begin
            if (prio_q[s*PRIO_W +: PRIO_W] > thr_c) any_above = 1'b1;
            if (prio_q[s*PRIO_W +: PRIO_W] > max_p) begin
              max_p     = prio_q[s*PRIO_W +: PRIO_W];
              first_max = s;
            end
          end
        end
      end

      // R7
      p_irq_tracks_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] == (id_c != '0));
      // R2
      p_winner_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> (pend_q[id_c] && !held_q[id_c] && en_q[c*VEC_W + int'(id_c)]));
      // R3
      p_above_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> (prio_q[int'(id_c)*PRIO_W +: PRIO_W] > thr_c));
      // R4
      p_top_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> (prio_q[int'(id_c)*PRIO_W +: PRIO_W] == max_p));
      // R5
      p_lowest_on_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> (int'(id_c) == first_max));
      // R6
      p_idle_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_above |-> (id_c == '0));
      // R6
      p_busy_when_some_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_above |-> irq_o[c]);
      // R10
      p_id_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(id_c) < N_SRC);
    end
  endgenerate
endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pend_i     (pend_i),
  .held_i     (held_i),
  .en_i       (en_i),
  .prio_i     (prio_i),
  .thr_i      (thr_i),
  .claim_id_o (claim_id_o),
  .irq_o      (irq_o)
);

// File: tb/prio_irq_arbiter_bench.sv
`timescale 1ns/1ps
module prio_irq_arbiter_bench;
  localparam int NS   = 40;
  localparam int NC   = 2;
  localparam int VW   = 64;
  localparam int IW   = 6;
  localparam int PW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [VW-1:0]   pend = '0;
  logic [VW-1:0]   held = '0;
  logic [NC*VW-1:0] en = '0;
  logic [NS*PW-1:0] prio = '0;
  logic [NC*PW-1:0] thr = '0;
  logic [NC*IW-1:0] claim_id;
  logic [NC-1:0]   irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_arbiter #(.N_SRC(NS), .N_CTX(NC)) u_prio_irq_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend),
    .held_i     (held),
    .en_i       (en),
    .prio_i     (prio),
    .thr_i      (thr),
    .claim_id_o (claim_id),
    .irq_o      (irq)
  );

  // Expected identifier: scan upward, replace only on a strictly larger priority.
  function automatic int model_id(int c);
    int best = 0;
    int mx = int'(thr[c*PW +: PW]);
    for (int s = 1; s < NS; s++) begin
      if (pend[s] && !held[s] && en[c*VW + s] && int'(prio[s*PW +: PW]) > mx) begin
        best = s;
        mx = int'(prio[s*PW +: PW]);
      end
    end
    return best;
  endfunction

  task automatic check_val(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic check_ctx(int c, string tag, int exp);
    check_val(tag, int'(claim_id[c*IW +: IW]), exp);
    check_val({tag, " R7"}, int'(irq[c]), (exp != 0) ? 1 : 0);
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_model(string tag);
    for (int c = 0; c < NC; c++) check_ctx(c, tag, model_id(c));
  endtask

  task automatic clear_all();
    pend = '0; held = '0; en = '0; prio = '0; thr = '0;
  endtask

  task automatic set_src(int s, int p, bit en0, bit en1);
    pend[s] = 1'b1;
    prio[s*PW +: PW] = PW'(p);
    en[s] = en0;
    en[VW + s] = en1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: drive a qualifying source while reset is held
    set_src(5, 6, 1, 1);
    repeat (3) @(negedge clk);
    check_ctx(0, "R1 reset ctx0", 0);
    check_ctx(1, "R1 reset ctx1", 0);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check_ctx(0, "R4 single source", 5);

    // R2: each gating bit
    clear_all(); set_src(9, 4, 1, 0); settle();
    check_ctx(0, "R2 enabled", 9);
    held[9] = 1'b1; settle();
    check_ctx(0, "R2 in-flight blocks", 0);
    held[9] = 1'b0; pend[9] = 1'b0; settle();
    check_ctx(0, "R2 not pending", 0);
    pend[9] = 1'b1; en[9] = 1'b0; settle();
    check_ctx(0, "R2 not enabled", 0);

    // R11: enable only in context 1, different thresholds
    clear_all(); set_src(12, 3, 0, 1); set_src(20, 5, 1, 0); settle();
    check_ctx(0, "R11 ctx0", 20);
    check_ctx(1, "R11 ctx1", 12);
    thr[0 +: PW] = 3'd6; settle();
    check_ctx(0, "R11 ctx0 masked", 0);
    check_ctx(1, "R11 ctx1 unaffected", 12);

    // R3: equal to threshold loses, one below wins
    clear_all(); set_src(17, 4, 1, 1); thr = {3'd3, 3'd4}; settle();
    check_ctx(0, "R3 equal threshold", 0);
    check_ctx(1, "R3 above threshold", 17);

    // R5 tie across words, R4 higher wins in upper word
    clear_all(); set_src(33, 4, 1, 1); set_src(7, 4, 1, 1); settle();
    check_ctx(0, "R5 tie lowest id", 7);
    prio[33*PW +: PW] = 3'd5; settle();
    check_ctx(0, "R4 higher priority upper word", 33);
    set_src(39, 7, 1, 1); settle();
    check_ctx(0, "R4 top slot", 39);

    // R8: priority 0 with threshold 0
    clear_all(); set_src(3, 0, 1, 1); settle();
    check_ctx(0, "R8 zero priority", 0);

    // R6: slot 0 fully set with max priority
    clear_all(); set_src(0, 7, 1, 1); settle();
    check_ctx(0, "R6 slot zero", 0);
    check_ctx(1, "R6 slot zero ctx1", 0);

    // R10: padding bits set around a real winner
    clear_all(); set_src(25, 2, 1, 1);
    pend[VW-1:NS] = '1; en[VW-1:NS] = '1; en[2*VW-1:VW+NS] = '1; settle();
    check_ctx(0, "R10 padding ignored", 25);
    check_ctx(1, "R10 padding ignored ctx1", 25);

    // R9: outputs hold until the next rising edge
    clear_all(); set_src(11, 3, 1, 1); settle();
    set_src(30, 6, 1, 1);
    #1;
    check_ctx(0, "R9 before edge", 11);
    @(negedge clk);
    check_ctx(0, "R9 after edge", 30);

    // R4/R5/R3 sweep over every threshold with varied patterns
    for (int t = 0; t < 8; t++) begin
      for (int it = 0; it < 150; it++) begin
        pend = {$urandom, $urandom};
        held = {$urandom, $urandom} & {$urandom, $urandom};
        en   = {$urandom, $urandom, $urandom, $urandom};
        for (int s = 0; s < NS; s++) prio[s*PW +: PW] = PW'($urandom % 8);
        thr = {PW'(7 - t), PW'(t)};
        settle();
        check_model("R4 sweep");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule